// File: doc/BRIEF.md
# Message record/playback sequencer

This block is the digital controller of a segmented message store. A falling chip-enable captures a start segment from the address inputs. It also samples the play/record line: high selects playback, low selects recording. From then on, each segment-advance tick moves a segment pointer forward by one. The pointer drives a one-bit-per-segment marker array through a read/write port. That array records where each message ends.

A record cycle clears the marker of every segment it passes. It ends when chip-enable is released or power-down is raised, and it then sets the marker at the segment where it stopped. Playback stops on a tick taken while the pointer sits on a set marker. The end-of-message pin pulses low at that point. In address mode, holding chip-enable low carries playback on past the marker. Running off the last segment pulses the overflow pin low. After that, the overflow pin echoes chip-enable until power-down sends the pointer home.

A low-supply flag holds the end-of-message pin low and blocks recording. In push-button mode, the end-of-message pin instead shows an active-high run signal. The analog path, cell programming and oscillator lie outside this block.

Top module: `msg_seq_top`

## Requirements
- R1: After reset, eom_run and ovf_n are high, mark_addr is 0 and mark_we is low.
- R2: A falling edge of ce_n captures addr_in as the pointer. It also samples play_nrec, where 1 selects playback and 0 selects recording. Each later rising edge of seg_tick advances the pointer by exactly one.
- R3: While recording, each tick writes 0 to the marker of the segment being left. When ce_n goes high or pd goes high, recording ends and a 1 is written to the marker at the current pointer.
- R4: During playback, a tick taken while the current segment's marker reads 1 ends playback, and the pointer stays on that segment. This applies when ce_n is high or in push-button mode. Further ticks do not move the pointer.
- R5: In address mode, each marker reached during playback drives eom_run low for exactly PULSE_CYC clock cycles.
- R6: In address mode with ce_n held low, playback passes a set marker and advances to the next segment.
- R7: A tick taken while the pointer is on the last segment (SEGMENTS-1) does not advance the pointer. Instead, ovf_n goes low for PULSE_CYC cycles and then follows ce_n until pd is raised. No marker is written, and further ticks are ignored.
- R8: Raising pd returns the pointer to 0, idles the block and ends the overflow condition, so that ovf_n is high.
- R9: While low_vdd is high, eom_run is held low and a record request is ignored, leaving the pointer unchanged. Playback still runs.
- R10: With pb_mode high, eom_run is high while recording or playing and low otherwise.
- R11: All control inputs pass through SYNC_STAGES flip-flops. A seg_tick held high for many cycles advances the pointer only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low; its falling edge starts a cycle |
| pd | input | 1 | Power-down; high sends the pointer home and idles |
| play_nrec | input | 1 | 1 = playback, 0 = record, sampled on ce_n fall |
| addr_in | input | ADDR_W | Start segment |
| seg_tick | input | 1 | Segment-advance strobe (rising edge) |
| low_vdd | input | 1 | Supply below threshold |
| pb_mode | input | 1 | Push-button mode select; 0 = address mode |
| eom_run | output | 1 | End-of-message pulse (active low) or run level in push-button mode |
| ovf_n | output | 1 | Overflow, active low |
| mark_addr | output | ADDR_W | Marker array address (the current pointer) |
| mark_we | output | 1 | Marker write strobe |
| mark_wdata | output | 1 | Marker write value |
| mark_rdata | input | 1 | Marker value at mark_addr, combinational |

## Verification
Record-then-play pairs are swept over start segments 0 to 8 and message lengths 0 to 2 on a 12-segment store. Each pair checks that every passed marker is cleared, that exactly one marker is set at the stop point, and that playback halts on that segment with a single end-of-message pulse. Separate patterns hold chip-enable low through a marker, which separates the continue path from the stop path. Runs into the last segment in both record and playback show the overflow pulse against the chip-enable echo. Power-down during recording, a low-supply record attempt, push-button run levels and a tick held high for many cycles cover the remaining paths.

// File: rtl/msg_seq_pkg.sv
// Package: shared state encoding and synchroniser bit positions for the
// message record/playback sequencer. Assumes nothing beyond 1800-2017.
package msg_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REC  = 2'd1,
        ST_PLAY = 2'd2,
        ST_OVF  = 2'd3
    } seq_state_e;

    // bit positions inside the synchronised control vector
    localparam int SB_CE_N  = 0;
    localparam int SB_PD    = 1;
    localparam int SB_PR    = 2;
    localparam int SB_TICK  = 3;
    localparam int SB_LOWV  = 4;
    localparam int SB_PB    = 5;
    localparam int SB_COUNT = 6;

endpackage

// File: rtl/msg_sync.sv
// Module: multi-bit flip-flop synchroniser for asynchronous control levels.
// Assumes each bit is an independent level; no bus coherence is implied.
module msg_sync #(
    parameter int              WIDTH   = 6,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    // shift the raw inputs through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/msg_pulse.sv
// Module: fixed-length pulse stretcher. A one-cycle trigger yields LEN
// cycles of 'active', starting the cycle after the trigger. Retrigger restarts.
module msg_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active
);

    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    // load on trigger, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (trig)           cnt_q <= CW'(LEN);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> active); // R5

endmodule

// File: rtl/msg_seq_ctrl.sv
// Module: sequencing core. Holds the segment pointer and the cycle state,
// decodes chip-enable and tick edges, and drives the marker write port.
// Assumes all inputs except addr_in and mark_rdata are already synchronised;
// addr_in is stable around the chip-enable fall; mark_rdata is combinational.
module msg_seq_ctrl
    import msg_seq_pkg::*;
#(
    parameter int SEGMENTS = 600,
    parameter int ADDR_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_s,
    input  logic              pd_s,
    input  logic              pr_s,
    input  logic              tick_s,
    input  logic              lowv_s,
    input  logic              pb_s,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              mark_rdata,
    output logic [ADDR_W-1:0] ptr,
    output logic              mark_we,
    output logic              mark_wdata,
    output logic              eom_trig,
    output logic              ovf_trig,
    output seq_state_e        state
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(SEGMENTS - 1);

    seq_state_e        st_q, st_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic              ce_prev_q, tick_prev_q;
    logic              ce_fall, tick_rise, at_end;

    // remember last synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_prev_q   <= 1'b1;
            tick_prev_q <= 1'b0;
        end else begin
            ce_prev_q   <= ce_n_s;
            tick_prev_q <= tick_s;
        end
    end

    assign ce_fall   = ce_prev_q & ~ce_n_s;
    assign tick_rise = tick_s & ~tick_prev_q;
    assign at_end    = (ptr_q >= LAST);

    // next-state, pointer and marker-port decode
    always_comb begin
        st_d       = st_q;
        ptr_d      = ptr_q;
        mark_we    = 1'b0;
        mark_wdata = 1'b0;
        eom_trig   = 1'b0;
        ovf_trig   = 1'b0;
        if (pd_s) begin
            if (st_q == ST_REC) begin
                mark_we    = 1'b1;
                mark_wdata = 1'b1;
            end
            st_d  = ST_IDLE;
            ptr_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (ce_fall) begin
                        if (pr_s) begin
                            st_d  = ST_PLAY;
                            ptr_d = addr_in;
                        end else if (!lowv_s) begin
                            st_d  = ST_REC;
                            ptr_d = addr_in;
                        end
                    end
                end
                ST_REC: begin
                    if (ce_n_s) begin
                        mark_we    = 1'b1;
                        mark_wdata = 1'b1;
                        st_d       = ST_IDLE;
                    end else if (tick_rise) begin
                        if (at_end) begin
                            st_d     = ST_OVF;
                            ovf_trig = 1'b1;
                        end else begin
                            mark_we = 1'b1;
                            ptr_d   = ptr_q + 1'b1;
                        end
                    end
                end
                ST_PLAY: begin
                    if (tick_rise) begin
                        if (mark_rdata) eom_trig = 1'b1;
                        if (mark_rdata && (pb_s || ce_n_s)) begin
                            st_d = ST_IDLE;
                        end else if (at_end) begin
                            st_d     = ST_OVF;
                            ovf_trig = 1'b1;
                        end else begin
                            ptr_d = ptr_q + 1'b1;
                        end
                    end
                end
                ST_OVF: begin
                    st_d = ST_OVF;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state and pointer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ptr_q <= '0;
        end else begin
            st_q  <= st_d;
            ptr_q <= ptr_d;
        end
    end

    assign ptr   = ptr_q;
    assign state = st_q;

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && !pd_s) |=> (ptr_q == $past(ptr_q) || ptr_q == $past(ptr_q) + 1'b1)); // R2

    AST_MARK_ENDS_REC: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_we && mark_wdata) |=> (st_q != ST_REC)); // R3

    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OVF && !pd_s) |=> (st_q == ST_OVF)); // R7

    AST_PD_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        pd_s |=> (ptr_q == '0 && st_q == ST_IDLE)); // R8

    AST_NO_REC_LOWV: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && lowv_s) |=> (st_q != ST_REC)); // R9

endmodule

// File: rtl/msg_seq_top.sv
// Module: message record/playback sequencer top. Synchronises the control
// inputs, runs the sequencing core, stretches end-of-message and overflow
// pulses and muxes the output pins. Assumes SEGMENTS <= 2**ADDR_W and
// a combinational marker array read at mark_addr.
module msg_seq_top
    import msg_seq_pkg::*;
#(
    parameter int SEGMENTS    = 600,
    parameter int ADDR_W      = 10,
    parameter int PULSE_CYC   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              pd,
    input  logic              play_nrec,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              seg_tick,
    input  logic              low_vdd,
    input  logic              pb_mode,
    output logic              eom_run,
    output logic              ovf_n,
    output logic [ADDR_W-1:0] mark_addr,
    output logic              mark_we,
    output logic              mark_wdata,
    input  logic              mark_rdata
);

    localparam logic [SB_COUNT-1:0] SYNC_RST = SB_COUNT'(1) << SB_CE_N;

    logic [SB_COUNT-1:0] raw_v, syn_v;
    logic                eom_trig, ovf_trig, eom_act, ovf_act, running;
    seq_state_e          state;

    assign raw_v[SB_CE_N] = ce_n;
    assign raw_v[SB_PD]   = pd;
    assign raw_v[SB_PR]   = play_nrec;
    assign raw_v[SB_TICK] = seg_tick;
    assign raw_v[SB_LOWV] = low_vdd;
    assign raw_v[SB_PB]   = pb_mode;

    msg_sync #(
        .WIDTH   (SB_COUNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_v),
        .q     (syn_v)
    );

    msg_seq_ctrl #(
        .SEGMENTS (SEGMENTS),
        .ADDR_W   (ADDR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n_s     (syn_v[SB_CE_N]),
        .pd_s       (syn_v[SB_PD]),
        .pr_s       (syn_v[SB_PR]),
        .tick_s     (syn_v[SB_TICK]),
        .lowv_s     (syn_v[SB_LOWV]),
        .pb_s       (syn_v[SB_PB]),
        .addr_in    (addr_in),
        .mark_rdata (mark_rdata),
        .ptr        (mark_addr),
        .mark_we    (mark_we),
        .mark_wdata (mark_wdata),
        .eom_trig   (eom_trig),
        .ovf_trig   (ovf_trig),
        .state      (state)
    );

    msg_pulse #(.LEN(PULSE_CYC)) u_eom_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (eom_trig),
        .active (eom_act)
    );

    msg_pulse #(.LEN(PULSE_CYC)) u_ovf_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (ovf_trig),
        .active (ovf_act)
    );

    assign running = (state == ST_REC) || (state == ST_PLAY);

    // end-of-message pin: low-supply hold, run level, or stretched pulse
    always_comb begin
        if (syn_v[SB_LOWV])     eom_run = 1'b0;
        else if (syn_v[SB_PB])  eom_run = running;
        else                    eom_run = ~eom_act;
    end

    // overflow pin: pulse first, then echo of chip-enable until power-down
    always_comb begin
        if (state == ST_OVF)    ovf_n = ovf_act ? 1'b0 : syn_v[SB_CE_N];
        else                    ovf_n = 1'b1;
    end

    AST_OVF_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        syn_v[SB_PD] |=> ovf_n); // R8

endmodule

// File: tb/tb_msg_seq_top.sv
`timescale 1ns/1ps
module tb_msg_seq_top;

    localparam int SEG = 12;
    localparam int AW  = 4;
    localparam int PL  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, pd = 1'b0, play_nrec = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          seg_tick = 1'b0, low_vdd = 1'b0, pb_mode = 1'b0;
    logic          eom_run, ovf_n, mark_we, mark_wdata, mark_rdata;
    logic [AW-1:0] mark_addr;

    logic          mem [16];
    logic          preset_req = 1'b0;
    logic          preset_val = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int eom_cnt = 0, eom_last = 0, eom_pulses = 0;
    int ovf_cnt = 0, ovf_last = 0, ovf_pulses = 0;

    always #2 clk = ~clk;

    msg_seq_top #(
        .SEGMENTS (SEG), .ADDR_W (AW), .PULSE_CYC (PL), .SYNC_STAGES (2)
    ) dut (
        .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .pd (pd),
        .play_nrec (play_nrec), .addr_in (addr_in), .seg_tick (seg_tick),
        .low_vdd (low_vdd), .pb_mode (pb_mode), .eom_run (eom_run),
        .ovf_n (ovf_n), .mark_addr (mark_addr), .mark_we (mark_we),
        .mark_wdata (mark_wdata), .mark_rdata (mark_rdata)
    );

    // marker array model
    assign mark_rdata = mem[mark_addr];
    always @(posedge clk) begin
        if (preset_req) begin
            for (int i = 0; i < 16; i++) mem[i] <= preset_val;
        end else if (mark_we) begin
            mem[mark_addr] <= mark_wdata;
        end
    end

    // low-pulse length monitors
    always @(negedge clk) begin
        if (!eom_run) eom_cnt++;
        else begin
            if (eom_cnt != 0) begin eom_last = eom_cnt; eom_pulses++; end
            eom_cnt = 0;
        end
        if (!ovf_n) ovf_cnt++;
        else begin
            if (ovf_cnt != 0) begin ovf_last = ovf_cnt; ovf_pulses++; end
            ovf_cnt = 0;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic preset(input logic v);
        @(negedge clk); preset_val = v; preset_req = 1'b1;
        @(negedge clk); preset_req = 1'b0;
    endtask

    task automatic pd_pulse();
        @(negedge clk); pd = 1'b1; cyc(6); pd = 1'b0; cyc(4);
    endtask

    task automatic tick();
        @(negedge clk); seg_tick = 1'b1; cyc(3); seg_tick = 1'b0; cyc(4);
    endtask

    task automatic start_hold(input int a, input logic play);
        @(negedge clk); addr_in = AW'(a); play_nrec = play; ce_n = 1'b0; cyc(6);
    endtask

    task automatic release_ce();
        @(negedge clk); ce_n = 1'b1; cyc(6);
    endtask

    initial begin
        int p0;
        cyc(3);
        @(negedge clk); rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check("R1 eom_run", eom_run, 1);
        check("R1 ovf_n", ovf_n, 1);
        check("R1 mark_addr", mark_addr, 0);
        check("R1 mark_we", mark_we, 0);

        // R2 R3 R4 R5 record/play sweep
        for (int s = 0; s <= 8; s++) begin
            for (int len = 0; len <= 2; len++) begin
                preset(1'b1);
                pd_pulse();
                start_hold(s, 1'b0);
                check("R2 start ptr", mark_addr, s);
                for (int k = 0; k < len; k++) tick();
                check("R2 rec ptr", mark_addr, s + len);
                release_ce();
                for (int k = 0; k < len; k++) check("R3 cleared", mem[s+k], 0);
                check("R3 marker set", mem[s+len], 1);
                pd_pulse();
                start_hold(s, 1'b1);
                release_ce();
                check("R2 play start", mark_addr, s);
                for (int k = 0; k < len; k++) tick();
                p0 = eom_pulses;
                tick();
                cyc(PL + 2);
                check("R4 stop ptr", mark_addr, s + len);
                check("R5 eom count", eom_pulses - p0, 1);
                check("R5 eom length", eom_last, PL);
                tick();
                check("R4 no move", mark_addr, s + len);
            end
        end

        // R6 continue past marker with ce_n held low
        preset(1'b1);
        pd_pulse();
        start_hold(3, 1'b0); tick(); release_ce();
        pd_pulse();
        p0 = eom_pulses;
        start_hold(3, 1'b1);
        tick(); tick();
        cyc(PL + 2);
        check("R6 passed marker", mark_addr, 5);
        check("R6 eom pulse", eom_pulses - p0, 1);
        release_ce();

        // R7 overflow during playback with ce_n high
        preset(1'b0);
        pd_pulse();
        start_hold(9, 1'b1); release_ce();
        p0 = ovf_pulses;
        tick(); tick(); tick();
        cyc(PL + 2);
        check("R7 ovf pulse count", ovf_pulses - p0, 1);
        check("R7 ovf pulse len", ovf_last, PL);
        check("R7 ptr at last", mark_addr, SEG - 1);
        @(negedge clk); ce_n = 1'b0; cyc(6);
        check("R7 follows ce low", ovf_n, 0);
        release_ce();
        check("R7 follows ce high", ovf_n, 1);
        tick();
        check("R7 tick ignored", mark_addr, SEG - 1);
        pd_pulse();
        check("R8 ptr home", mark_addr, 0);
        check("R8 ovf cleared", ovf_n, 1);

        // R7 overflow during record: no marker written
        preset(1'b0);
        pd_pulse();
        start_hold(10, 1'b0);
        tick(); tick();
        check("R7 rec ovf low", ovf_n, 0);
        release_ce();
        check("R7 rec ovf follows", ovf_n, 1);
        check("R7 no marker", mem[SEG-1], 0);
        pd_pulse();

        // R3 R8 power-down ends recording with a marker
        preset(1'b0);
        pd_pulse();
        start_hold(2, 1'b0);
        tick(); tick();
        @(negedge clk); pd = 1'b1; cyc(6);
        check("R3 pd marker", mem[4], 1);
        check("R8 pd ptr", mark_addr, 0);
        pd = 1'b0;
        release_ce();

        // R9 low supply
        preset(1'b0);
        @(negedge clk); low_vdd = 1'b1; cyc(6);
        check("R9 eom held low", eom_run, 0);
        pd_pulse();
        start_hold(5, 1'b0);
        tick(); tick();
        check("R9 record ignored", mark_addr, 0);
        check("R9 no write", mem[5], 0);
        release_ce();
        start_hold(5, 1'b1); release_ce();
        tick();
        check("R9 play works", mark_addr, 6);
        @(negedge clk); low_vdd = 1'b0;
        pd_pulse();

        // R10 push-button run level
        @(negedge clk); pb_mode = 1'b1; cyc(6);
        check("R10 idle run low", eom_run, 0);
        start_hold(2, 1'b0);
        check("R10 rec run high", eom_run, 1);
        release_ce();
        check("R10 run low after rec", eom_run, 0);
        pd_pulse();
        start_hold(2, 1'b1); release_ce();
        check("R10 play run high", eom_run, 1);
        tick();
        check("R10 run low at marker", eom_run, 0);
        check("R10 stop ptr", mark_addr, 2);
        @(negedge clk); pb_mode = 1'b0;
        pd_pulse();

        // R11 long tick counts once
        preset(1'b0);
        pd_pulse();
        start_hold(0, 1'b1); release_ce();
        @(negedge clk); seg_tick = 1'b1; cyc(20); seg_tick = 1'b0; cyc(4);
        check("R11 single step", mark_addr, 1);
        pd_pulse();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule